// File: doc/BRIEF.md
# Pin-Addressed Register I2C Target

This block is an I2C target that lives entirely in the system clock domain. The SCL and SDA pins are passed through a synchronizer. A small protocol engine recognises START and STOP, takes in the address byte and acknowledges it. It then either loads a register pointer and stores data bytes, or sends register contents most significant bit first. SDA is driven only through an open-drain enable: when the enable is high, the line is pulled low.

The 7-bit bus address is formed from five stored bits and two hardware strap pins. The top stored bit is inverted on its way into the address, so the reset value of the stored field gives an address with its top bit set. The register map holds several values: an angle and a magnitude, each split into a high byte and a six-bit low byte, a gain value, four diagnostic flags, a programming control byte, a split zero-position value, and the stored address bits. A host sets the register pointer with a write and can then read a run of bytes with a repeated START. Every byte moves the pointer forward by one, whether it is read or written.

Top module: `pinaddr_i2c_target`

## Requirements
- R1: The target acknowledges an address byte, by pulling SDA low during the ninth clock, only when the byte's upper seven bits equal {~S[4], S[3:0], addr_sel_hi, addr_sel_lo}, where S is the stored 5-bit field at register 0x15. With S at its reset value 0 and both pins low, the address is 0x40.
- R2: After an address that does not match, SDA is never pulled low until the next START, and a later transaction to the correct address is served normally.
- R3: In a write, the first byte after the address loads the register pointer. Each following data byte is stored at the pointer, and the pointer then advances by one (8-bit wrap).
- R4: A random read (address+W, pointer byte, repeated START, address+R) returns the register at the pointer, most significant bit first.
- R5: In a read, the pointer advances after every byte, so sequential reads return consecutive registers. A master NACK ends the read and SDA stays released until STOP.
- R6: Writes to read-only or unmapped registers are acknowledged and change nothing. Register 0x03 keeps only bits 6, 3 and 0, register 0x15 keeps bits 4:0, and register 0x17 keeps bits 5:0. The other bits read 0.
- R7: Register 0xFE reads angle[13:6] and register 0xFF reads {2'b00, angle[5:0]}. Registers 0xFC and 0xFD read the magnitude with the same split.
- R8: Register 0xFA reads the gain input. Register 0xFB reads {4'b0, diag[3:0]}. Unmapped addresses read 0x00.
- R9: Register 0x15 reads back the stored bits without inversion (0x00 after reset). A write to it changes the address that is matched from the next START on.
- R10: zero_pos_o equals {reg 0x16, reg 0x17[5:0]}, and prog_ctrl_o mirrors register 0x03.
- R11: After reset, sda_oe is low and all writable registers are 0.
- R12: sda_oe changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe | output | 1 | High pulls SDA low |
| addr_sel_lo | input | 1 | Strap pin, address bit 0 |
| addr_sel_hi | input | 1 | Strap pin, address bit 1 |
| angle_i | input | VAL_W | Angle value to expose |
| magnitude_i | input | VAL_W | Magnitude value to expose |
| agc_i | input | AGC_W | Gain value to expose |
| diag_i | input | DIAG_W | Diagnostic flags (bit3 comp-high, bit2 comp-low, bit1 overflow, bit0 offset done) |
| zero_pos_o | output | VAL_W | Stored zero position |
| prog_ctrl_o | output | 8 | Stored programming control byte |

## Verification
The in-RTL assertions cover four rules on every cycle: SDA changes only while SCL is low, the target stays silent after an address miss, each written byte advances the pointer by exactly one, and a read-only write leaves all stored registers untouched. They also check that a START always re-arms address reception and that a NACK releases the line. Other behaviours appear only in bench scenarios. These are the address arithmetic with the inverted stored bit and the strap pins, the byte splitting of the 14-bit values, the bit masks of the writable registers, the pointer wrap from 0xFF to 0x00, and the address change that follows a write to register 0x15.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_REG,
      ST_WDATA,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } eng_state_t;

   // register offsets the host decodes
   localparam logic [7:0] RA_PROG    = 8'h03;
   localparam logic [7:0] RA_DEVADDR = 8'h15;
   localparam logic [7:0] RA_ZHI     = 8'h16;
   localparam logic [7:0] RA_ZLO     = 8'h17;
   localparam logic [7:0] RA_AGC     = 8'hFA;
   localparam logic [7:0] RA_DIAG    = 8'hFB;
   localparam logic [7:0] RA_MHI     = 8'hFC;
   localparam logic [7:0] RA_MLO     = 8'hFD;
   localparam logic [7:0] RA_AHI     = 8'hFE;
   localparam logic [7:0] RA_ALO     = 8'hFF;

   // verify (6), burn (3), enable (0)
   localparam logic [7:0] PROG_MASK  = 8'h49;

   function automatic logic is_writable(input logic [7:0] a);
      return (a == RA_PROG) || (a == RA_DEVADDR) || (a == RA_ZHI) || (a == RA_ZLO);
   endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_p;
   logic              sda_p;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cr_line_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_i;
                  sda_chain[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[i] <= 1'b1;
                  sda_chain[i] <= 1'b1;
               end else begin
                  scl_chain[i] <= scl_chain[i-1];
                  sda_chain[i] <= sda_chain[i-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_chain[STAGES-1];
         sda_p <= sda_chain[STAGES-1];
      end
   end

   assign scl_s     = scl_chain[STAGES-1];
   assign sda_s     = sda_chain[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cr_regmap.sv
module i2cr_regmap
   import i2cr_pkg::*;
#(
   parameter int VAL_W  = 14,
   parameter int AGC_W  = 8,
   parameter int DIAG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        rd_addr,
   output logic [7:0]        rd_data,
   input  logic              addr_sel_lo,
   input  logic              addr_sel_hi,
   output logic [6:0]        dev_addr,
   input  logic [VAL_W-1:0]  angle_i,
   input  logic [VAL_W-1:0]  magnitude_i,
   input  logic [AGC_W-1:0]  agc_i,
   input  logic [DIAG_W-1:0] diag_i,
   output logic [VAL_W-1:0]  zero_pos_o,
   output logic [7:0]        prog_ctrl_o
);
   localparam int LO_W = VAL_W - 8;

   logic [7:0]      prog_q;
   logic [4:0]      devaddr_q;
   logic [7:0]      zhi_q;
   logic [LO_W-1:0] zlo_q;

   logic [7:0] ang_hi, ang_lo, mag_hi, mag_lo, zlo_byte, agc_byte, diag_byte;

   generate
      if (VAL_W < 9 || VAL_W > 16) begin : g_bad_val
         $error("i2cr_regmap: VAL_W must lie in 9..16");
      end
      if (AGC_W < 1 || AGC_W > 8) begin : g_bad_agc
         $error("i2cr_regmap: AGC_W must lie in 1..8");
      end
      if (DIAG_W < 1 || DIAG_W > 7) begin : g_bad_diag
         $error("i2cr_regmap: DIAG_W must lie in 1..7");
      end

      if (LO_W == 8) begin : g_lo_full
         assign ang_lo   = angle_i[7:0];
         assign mag_lo   = magnitude_i[7:0];
         assign zlo_byte = zlo_q;
      end else begin : g_lo_pad
         assign ang_lo   = {{(8-LO_W){1'b0}}, angle_i[LO_W-1:0]};
         assign mag_lo   = {{(8-LO_W){1'b0}}, magnitude_i[LO_W-1:0]};
         assign zlo_byte = {{(8-LO_W){1'b0}}, zlo_q};
      end

      if (AGC_W == 8) begin : g_agc_full
         assign agc_byte = agc_i;
      end else begin : g_agc_pad
         assign agc_byte = {{(8-AGC_W){1'b0}}, agc_i};
      end
   endgenerate

   assign ang_hi    = angle_i[VAL_W-1:LO_W];
   assign mag_hi    = magnitude_i[VAL_W-1:LO_W];
   assign diag_byte = {{(8-DIAG_W){1'b0}}, diag_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q    <= '0;
         devaddr_q <= '0;
         zhi_q     <= '0;
         zlo_q     <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_PROG:    prog_q    <= wr_data & PROG_MASK;
            RA_DEVADDR: devaddr_q <= wr_data[4:0];
            RA_ZHI:     zhi_q     <= wr_data;
            RA_ZLO:     zlo_q     <= wr_data[LO_W-1:0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         RA_PROG:    rd_data = prog_q;
         RA_DEVADDR: rd_data = {3'b000, devaddr_q};
         RA_ZHI:     rd_data = zhi_q;
         RA_ZLO:     rd_data = zlo_byte;
         RA_AGC:     rd_data = agc_byte;
         RA_DIAG:    rd_data = diag_byte;
         RA_MHI:     rd_data = mag_hi;
         RA_MLO:     rd_data = mag_lo;
         RA_AHI:     rd_data = ang_hi;
         RA_ALO:     rd_data = ang_lo;
         default:    rd_data = 8'h00;
      endcase
   end

   // stored top bit enters the address inverted
   assign dev_addr    = {~devaddr_q[4], devaddr_q[3:0], addr_sel_hi, addr_sel_lo};
   assign zero_pos_o  = {zhi_q, zlo_q};
   assign prog_ctrl_o = prog_q;

   AST_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_writable(wr_addr)) |=> $stable({prog_q, devaddr_q, zhi_q, zlo_q})); // R6

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
   import i2cr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [6:0] dev_addr,
   input  logic [7:0] rd_data,
   output logic [7:0] ptr,
   output logic       wr_en,
   output logic [7:0] wr_data,
   output logic       sda_oe
);
   eng_state_t state;
   logic [3:0] cnt;
   logic [7:0] shreg;
   logic [6:0] txd;
   logic       in_ack;
   logic       is_rd;
   logic       more;
   logic       byte_done;

   assign byte_done = (cnt == 4'd8);
   assign wr_en     = (state == ST_WDATA) && scl_fall && byte_done && !in_ack
                      && !start_det && !stop_det;
   assign wr_data   = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         shreg  <= '0;
         txd    <= '0;
         in_ack <= 1'b0;
         is_rd  <= 1'b0;
         more   <= 1'b0;
         ptr    <= '0;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state  <= ST_ADDR;
         cnt    <= '0;
         in_ack <= 1'b0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         in_ack <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_REG, ST_WDATA: begin
               if (scl_rise && !in_ack && !byte_done) begin
                  shreg <= {shreg[6:0], sda_s};
                  cnt   <= cnt + 4'd1;
               end else if (scl_fall && in_ack) begin
                  in_ack <= 1'b0;
                  cnt    <= '0;
                  sda_oe <= 1'b0;
                  if (state == ST_ADDR) begin
                     if (is_rd) begin
                        state  <= ST_RDATA;
                        txd    <= rd_data[6:0];
                        sda_oe <= ~rd_data[7];
                     end else begin
                        state  <= ST_REG;
                     end
                  end else begin
                     state <= ST_WDATA;
                  end
               end else if (scl_fall && byte_done) begin
                  if (state == ST_ADDR) begin
                     if (shreg[7:1] == dev_addr) begin
                        sda_oe <= 1'b1;
                        in_ack <= 1'b1;
                        is_rd  <= shreg[0];
                     end else begin
                        state  <= ST_IGNORE;
                     end
                  end else if (state == ST_REG) begin
                     ptr    <= shreg;
                     sda_oe <= 1'b1;
                     in_ack <= 1'b1;
                  end else begin
                     ptr    <= ptr + 8'd1;
                     sda_oe <= 1'b1;
                     in_ack <= 1'b1;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise && !byte_done) begin
                  cnt <= cnt + 4'd1;
               end else if (scl_fall) begin
                  if (byte_done) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     ptr    <= ptr + 8'd1;
                     state  <= ST_RACK;
                  end else begin
                     sda_oe <= ~txd[6];
                     txd    <= {txd[5:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  more <= ~sda_s;
               end else if (scl_fall) begin
                  if (more) begin
                     state  <= ST_RDATA;
                     txd    <= rd_data[6:0];
                     sda_oe <= ~rd_data[7];
                  end else begin
                     state  <= ST_IGNORE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s); // R12

   AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe); // R2

   AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR) && !sda_oe && (cnt == 4'd0)); // R4

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == $past(ptr) + 8'd1)); // R3

   AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && scl_fall && !more && !start_det && !stop_det)
      |=> (state == ST_IGNORE) && !sda_oe); // R5

endmodule

// File: rtl/pinaddr_i2c_target.sv
module pinaddr_i2c_target #(
   parameter int SYNC_STAGES = 2,
   parameter int VAL_W       = 14,
   parameter int AGC_W       = 8,
   parameter int DIAG_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              addr_sel_lo,
   input  logic              addr_sel_hi,
   input  logic [VAL_W-1:0]  angle_i,
   input  logic [VAL_W-1:0]  magnitude_i,
   input  logic [AGC_W-1:0]  agc_i,
   input  logic [DIAG_W-1:0] diag_i,
   output logic [VAL_W-1:0]  zero_pos_o,
   output logic [7:0]        prog_ctrl_o
);
   logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0] ptr, wr_data, rd_data;
   logic       wr_en;
   logic [6:0] dev_addr;

   i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cr_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .dev_addr  (dev_addr),
      .rd_data   (rd_data),
      .ptr       (ptr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .sda_oe    (sda_oe)
   );

   i2cr_regmap #(.VAL_W(VAL_W), .AGC_W(AGC_W), .DIAG_W(DIAG_W)) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (ptr),
      .wr_data     (wr_data),
      .rd_addr     (ptr),
      .rd_data     (rd_data),
      .addr_sel_lo (addr_sel_lo),
      .addr_sel_hi (addr_sel_hi),
      .dev_addr    (dev_addr),
      .angle_i     (angle_i),
      .magnitude_i (magnitude_i),
      .agc_i       (agc_i),
      .diag_i      (diag_i),
      .zero_pos_o  (zero_pos_o),
      .prog_ctrl_o (prog_ctrl_o)
   );

endmodule

// File: tb/pinaddr_i2c_target_test.sv
module pinaddr_i2c_target_test;
   localparam int Q = 6;

   typedef logic [7:0] bq_t[$];
   typedef struct {
      logic [7:0] v;
      string      tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m_low = 1'b0;
   logic        sda_line;
   logic        sda_oe;
   logic        sel_lo = 1'b0, sel_hi = 1'b0;
   logic [13:0] angle = '0, mag = '0;
   logic [7:0]  agc = '0;
   logic [3:0]  diag = '0;
   logic [13:0] zero_pos;
   logic [7:0]  prog_ctrl;

   int checks = 0;
   int errors = 0;
   int oe_hi_changes = 0;
   logic prev_oe = 1'b0;

   item_t      exp_q[$];
   logic [7:0] act_q[$];

   always #2 clk = ~clk;

   assign sda_line = ~(sda_m_low | sda_oe);

   pinaddr_i2c_target uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_oe      (sda_oe),
      .addr_sel_lo (sel_lo),
      .addr_sel_hi (sel_hi),
      .angle_i     (angle),
      .magnitude_i (mag),
      .agc_i       (agc),
      .diag_i      (diag),
      .zero_pos_o  (zero_pos),
      .prog_ctrl_o (prog_ctrl)
   );

   // R12 watch: target enable must not move while SCL is high
   always @(negedge clk) begin
      if (rst_n && scl_m && (sda_oe != prev_oe)) oe_hi_changes++;
      prev_oe = sda_oe;
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t      e;
            logic [7:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a !== e.v) begin
               errors++;
               $display("FAIL %s read byte actual %h expected %h", e.tag, a, e.v);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m_low = 1'b0; scl_m = 1'b1; wait_q();
      sda_m_low = 1'b1; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_rstart();
      sda_m_low = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m_low = 1'b1; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_m_low = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m_low = 1'b0; wait_q();
   endtask

   task automatic clock_bit(input logic b, output logic s);
      sda_m_low = ~b; wait_q();
      scl_m = 1'b1; wait_q();
      s = sda_line; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
      clock_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic [7:0] e, input string tag, input logic mack);
      logic       s;
      logic [7:0] got;
      item_t      it;
      it.v = e; it.tag = tag;
      exp_q.push_back(it);
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         got[i] = s;
      end
      clock_bit(~mack, s);
      act_q.push_back(got);
   endtask

   task automatic wr_seq(input logic [6:0] dev, input logic [7:0] ra, input bq_t d, input string tag);
      logic ack;
      bus_start();
      wr_byte({dev, 1'b0}, ack);
      check({tag, " address ack"}, ack, 1'b1);
      wr_byte(ra, ack);
      check({tag, " pointer ack"}, ack, 1'b1);
      foreach (d[i]) begin
         wr_byte(d[i], ack);
         check({tag, " data ack"}, ack, 1'b1);
      end
      bus_stop();
   endtask

   task automatic rd_seq(input logic [6:0] dev, input logic [7:0] ra, input bq_t e, input string tag);
      logic ack;
      bus_start();
      wr_byte({dev, 1'b0}, ack);
      check({tag, " address ack"}, ack, 1'b1);
      wr_byte(ra, ack);
      check({tag, " pointer ack"}, ack, 1'b1);
      bus_rstart();
      wr_byte({dev, 1'b1}, ack);
      check({tag, " read address ack"}, ack, 1'b1);
      foreach (e[i]) rd_byte(e[i], tag, (i != e.size() - 1));
      bus_stop();
   endtask

   task automatic probe_nack(input logic [6:0] dev, input string tag);
      logic ack;
      int   drives;
      drives = 0;
      bus_start();
      wr_byte({dev, 1'b0}, ack);
      check({tag, " no address ack"}, ack, 1'b0);
      for (int i = 0; i < 9 * 4 * Q; i++) begin
         if (i == 0) begin
            fork
               wr_byte(8'h00, ack);
               begin
                  for (int k = 0; k < 9 * 4 * Q; k++) begin
                     @(negedge clk);
                     if (sda_oe) drives++;
                  end
               end
            join
         end
      end
      check({tag, " no drive after miss"}, drives, 0);
      bus_stop();
   endtask

   initial begin
      logic [7:0] ahi, alo, mhi, mlo;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R11 reset state
      check("R11 sda_oe", sda_oe, 1'b0);
      check("R11 zero_pos", zero_pos, 14'h0);
      check("R11 prog_ctrl", prog_ctrl, 8'h00);

      // R9 default stored address bits read 0, default address 0x40 (R1)
      rd_seq(7'h40, 8'h15, '{8'h00}, "R9 R1 R4 default address field");

      // R3 page write into zero position, R6 low-byte mask, R10 output
      wr_seq(7'h40, 8'h16, '{8'hAB, 8'hFF}, "R3 page write");
      check("R10 zero_pos", zero_pos, {8'hAB, 6'h3F});
      rd_seq(7'h40, 8'h16, '{8'hAB, 8'h3F}, "R5 R6 sequential zero readback");

      // R6 programming control mask, R10 mirror
      wr_seq(7'h40, 8'h03, '{8'hFF}, "R6 prog write");
      check("R10 prog_ctrl", prog_ctrl, 8'h49);
      rd_seq(7'h40, 8'h03, '{8'h49}, "R6 R4 prog readback");

      // R7 R8 R5 sequential read over the live values with wrap to 0x00
      angle = 14'h2D5A; mag = 14'h1234; agc = 8'h9C; diag = 4'b1001;
      ahi = angle[13:6]; alo = {2'b00, angle[5:0]};
      mhi = mag[13:6];   mlo = {2'b00, mag[5:0]};
      repeat (2) @(negedge clk);
      rd_seq(7'h40, 8'hFA, '{agc, {4'b0, diag}, mhi, mlo, ahi, alo, 8'h00},
             "R7 R8 R5 live value burst");

      // R6 write to read-only is acknowledged and discarded
      wr_seq(7'h40, 8'hFE, '{8'h00, 8'h00}, "R6 read-only write");
      rd_seq(7'h40, 8'hFE, '{ahi, alo}, "R6 R7 angle intact");
      check("R6 zero_pos intact", zero_pos, {8'hAB, 6'h3F});

      // R2 mismatching address
      probe_nack(7'h55, "R2");
      rd_seq(7'h40, 8'h16, '{8'hAB}, "R2 served after miss");

      // R1 strap pins
      sel_hi = 1'b1; sel_lo = 1'b0;
      repeat (2) @(negedge clk);
      probe_nack(7'h40, "R1 old address");
      rd_seq(7'h42, 8'h03, '{8'h49}, "R1 pin address");

      // R9 stored bits, inverted top bit
      wr_seq(7'h42, 8'h15, '{8'hFF}, "R9 address write");
      probe_nack(7'h42, "R9 previous address");
      rd_seq(7'h3E, 8'h15, '{8'h1F}, "R9 raw readback");
      wr_seq(7'h3E, 8'h15, '{8'h00}, "R9 restore");
      rd_seq(7'h42, 8'h15, '{8'h00}, "R9 restored address");

      repeat (10) @(negedge clk);
      check("R12 enable changes while SCL high", oe_hi_changes, 0);
      check("R5 released at end", sda_oe, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule